// File: doc/BRIEF.md
# Configuration Address Register and Router

This block sits on a simple processor I/O request port (valid, address, byte enables, read/write flag, write data) and holds the 32-bit configuration address register at I/O address 0x0CF8. A full four-byte access to that address claims the register: a write stores the enable bit and the address fields, and a read returns them. A narrower access to the same address is not claimed. It is forwarded unchanged as an ordinary downstream I/O cycle.

Each access to the configuration data window (0x0CFC to 0x0CFF) is classified from the stored register. The block compares the stored bus and device fields with a set of internal device numbers and with the secondary and subordinate bus numbers it receives on inputs. It then emits a registered, one-cycle routing result: a one-hot target (internal, bridge side, hub side) and a type bit. If the enable bit is clear, the data access is flagged as a pass-through I/O cycle instead. Generating the bus cycles and moving the data are left to neighbouring logic.

Top module: `cfg_addr_router`

## Requirements
- R1: After reset the stored register is 0x00000000 and cfg_claim, io_fwd and route_valid are low.
- R2: A request to 0x0CF8 with io_be = 4'b1111 pulses cfg_claim in the following cycle. A write stores the data, and a later read returns the stored value on cfg_rdata in its claim cycle. cfg_rdata is zero when no read is being answered.
- R3: A request to 0x0CF8 with any io_be other than 4'b1111 (and not 4'b0000) pulses io_fwd in the following cycle, does not raise cfg_claim, and leaves the stored register unchanged.
- R4: Bits 30:24 and 1:0 of the register always read as 0, whatever value was written.
- R5: A request to 0x0CFC..0x0CFF with nonzero io_be produces one outcome in the following cycle. If register bit 31 is 1, route_valid pulses with exactly one route_target bit set. If bit 31 is 0, io_fwd pulses and route_valid stays low.
- R6: The register fields are bus in 23:16, device in 15:11, function in 10:8 and register in 7:2. With bus 0 and a device equal to one of the internal device numbers (default 0, 1, 2), the route is internal (route_target = 3'b001) with route_type1 = 0.
- R7: With bus 0 and any other device number, the route is hub side (3'b100) with route_type1 = 0.
- R8: With a nonzero bus equal to sec_bus, the route is bridge side (3'b010) with route_type1 = 0.
- R9: With a bus greater than sec_bus and no greater than sub_bus, the route is bridge side with route_type1 = 1.
- R10: With a nonzero bus below sec_bus or above sub_bus, the route is hub side with route_type1 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_valid | input | 1 | I/O request present this cycle |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables |
| io_write | input | 1 | 1 = write, 0 = read |
| io_wdata | input | 32 | Write data |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| cfg_claim | output | 1 | Register claimed the request (one cycle later) |
| cfg_rdata | output | 32 | Read data of a claimed read |
| io_fwd | output | 1 | Request forwarded as a plain I/O cycle |
| route_valid | output | 1 | Routing result valid |
| route_target | output | 3 | One-hot target: 001 internal, 010 bridge, 100 hub |
| route_type1 | output | 1 | 1 = type 1 cycle, 0 = type 0 |

## Verification
The bench concentrates on the edges of the bus range. A bus exactly equal to the secondary number must give a type 0 bridge cycle. A bus exactly equal to the subordinate number must give a type 1 bridge cycle. A bus one above the subordinate number, or one below the secondary number, must go to the hub as type 1. A design with an off-by-one comparison would send one of these to the wrong port or with the wrong type. Narrow writes to the register address are checked by reading the register back afterwards, because a design that claims them would corrupt the stored address. Data accesses made with the enable bit clear are checked as well, because a design that routes them anyway would issue configuration cycles that software never enabled.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
    localparam int REG_W = 32;
    localparam logic [REG_W-1:0] CFG_WMASK = 32'h80FF_FFFC;

    typedef enum logic [2:0] {
        TGT_NONE     = 3'b000,
        TGT_INTERNAL = 3'b001,
        TGT_BRIDGE   = 3'b010,
        TGT_HUB      = 3'b100
    } tgt_e;

    typedef struct packed {
        logic             claim;
        logic [REG_W-1:0] rdata;
        logic             fwd;
        logic             rvalid;
        tgt_e             tgt;
        logic             type1;
    } resp_t;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_q
);
    logic [REG_W-1:0] cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = wdata & CFG_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    AST_WRITE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_q == ($past(wdata) & CFG_WMASK)); // R2

    AST_RSVD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q[30:24] == 7'd0) && (cfg_q[1:0] == 2'd0)); // R4
endmodule

// File: rtl/cfg_route_decide.sv
module cfg_route_decide
    import cfg_route_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int DEV_W   = 5,
    parameter int NUM_INT = 3,
    parameter logic [NUM_INT*DEV_W-1:0] INT_DEVS = {5'd2, 5'd1, 5'd0}
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [BUS_W-1:0] sec,
    input  logic [BUS_W-1:0] sub,
    output tgt_e             tgt,
    output logic             type1
);
    logic [NUM_INT-1:0] dev_hit;

    for (genvar g = 0; g < NUM_INT; g++) begin : g_int
        assign dev_hit[g] = (dev == INT_DEVS[g*DEV_W +: DEV_W]);
    end

    always_comb begin
        tgt   = TGT_HUB;
        type1 = 1'b0;
        if (bus == '0) begin
            tgt   = (|dev_hit) ? TGT_INTERNAL : TGT_HUB;
            type1 = 1'b0;
        end else if (bus == sec) begin
            tgt   = TGT_BRIDGE;
            type1 = 1'b0;
        end else if ((bus > sec) && (bus <= sub)) begin
            tgt   = TGT_BRIDGE;
            type1 = 1'b1;
        end else begin
            tgt   = TGT_HUB;
            type1 = 1'b1;
        end
    end
endmodule

// File: rtl/cfg_addr_router.sv
module cfg_addr_router
    import cfg_route_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 16'h0CF8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0CFC,
    parameter int BUS_W   = 8,
    parameter int DEV_W   = 5,
    parameter int NUM_INT = 3,
    parameter logic [NUM_INT*DEV_W-1:0] INT_DEVS = {5'd2, 5'd1, 5'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [3:0]        io_be,
    input  logic              io_write,
    input  logic [31:0]       io_wdata,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              cfg_claim,
    output logic [31:0]       cfg_rdata,
    output logic              io_fwd,
    output logic              route_valid,
    output logic [2:0]        route_target,
    output logic              route_type1
);
    localparam int BUS_LO = 16;
    localparam int DEV_LO = 11;

    logic             hit_cfg, hit_data, full_dw, reg_wr;
    logic [REG_W-1:0] cfg_q;
    tgt_e             dec_tgt;
    logic             dec_type1;
    resp_t            resp_d, resp_q;

    assign hit_cfg  = io_valid && (io_addr == CFG_ADDR) && (io_be != 4'b0000);
    assign hit_data = io_valid && (io_addr[ADDR_W-1:2] == DATA_ADDR[ADDR_W-1:2])
                      && (io_be != 4'b0000);
    assign full_dw  = (io_be == 4'b1111);
    assign reg_wr   = hit_cfg && full_dw && io_write;

    cfg_addr_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .wdata (io_wdata),
        .cfg_q (cfg_q)
    );

    cfg_route_decide #(
        .BUS_W   (BUS_W),
        .DEV_W   (DEV_W),
        .NUM_INT (NUM_INT),
        .INT_DEVS(INT_DEVS)
    ) u_dec (
        .bus   (cfg_q[BUS_LO +: BUS_W]),
        .dev   (cfg_q[DEV_LO +: DEV_W]),
        .sec   (sec_bus),
        .sub   (sub_bus),
        .tgt   (dec_tgt),
        .type1 (dec_type1)
    );

    always_comb begin
        resp_d = '0;
        if (hit_cfg) begin
            if (full_dw) begin
                resp_d.claim = 1'b1;
                if (!io_write) resp_d.rdata = cfg_q;
            end else begin
                resp_d.fwd = 1'b1;
            end
        end else if (hit_data) begin
            if (cfg_q[REG_W-1]) begin
                resp_d.rvalid = 1'b1;
                resp_d.tgt    = dec_tgt;
                resp_d.type1  = dec_type1;
            end else begin
                resp_d.fwd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign cfg_claim    = resp_q.claim;
    assign cfg_rdata    = resp_q.rdata;
    assign io_fwd       = resp_q.fwd;
    assign route_valid  = resp_q.rvalid;
    assign route_target = resp_q.tgt;
    assign route_type1  = resp_q.type1;

    AST_NARROW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cfg && !full_dw) |=> $stable(cfg_q)); // R3

    AST_NARROW_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cfg && !full_dw) |=> (io_fwd && !cfg_claim)); // R3

    AST_RDATA_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_claim |-> (cfg_rdata[30:24] == 7'd0) && (cfg_rdata[1:0] == 2'd0)); // R4

    AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> ($onehot0(route_target) && (route_target != 3'b000))); // R5

    AST_ROUTE_OR_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !(route_valid && io_fwd)); // R5

    AST_INTERNAL_TYPE0: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && route_target == 3'b001) |-> !route_type1); // R6
endmodule

// File: tb/cfg_addr_router_test.sv
module cfg_addr_router_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic        io_write = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [7:0]  sec_bus = '0;
    logic [7:0]  sub_bus = '0;
    logic        cfg_claim, io_fwd, route_valid, route_type1;
    logic [31:0] cfg_rdata;
    logic [2:0]  route_target;

    int n_checks = 0;
    int n_errors = 0;

    cfg_addr_router uut (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr),
        .io_be(io_be), .io_write(io_write), .io_wdata(io_wdata),
        .sec_bus(sec_bus), .sub_bus(sub_bus), .cfg_claim(cfg_claim),
        .cfg_rdata(cfg_rdata), .io_fwd(io_fwd), .route_valid(route_valid),
        .route_target(route_target), .route_type1(route_type1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input logic [7:0] bus,
                                       input logic [4:0] dev);
        return {en, 7'd0, bus, dev, 3'd1, 6'd5, 2'b00};
    endfunction

    // one request, outputs sampled on the following falling edge
    task automatic req(input logic [15:0] a, input logic [3:0] be, input bit wr,
                       input logic [31:0] d);
        @(negedge clk);
        io_valid = 1'b1; io_addr = a; io_be = be; io_write = wr; io_wdata = d;
        @(negedge clk);
        io_valid = 1'b0; io_be = '0; io_write = 1'b0;
    endtask

    task automatic read_reg(output logic [31:0] v);
        req(16'h0CF8, 4'hF, 1'b0, '0);
        v = cfg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk(!cfg_claim && !io_fwd && !route_valid, "R1",
            {29'd0, cfg_claim, io_fwd, route_valid}, 32'd0);
        read_reg(v);
        chk(v == 32'd0, "R1", v, 32'd0);
    endtask

    task automatic t_write_read;
        logic [31:0] v;
        req(16'h0CF8, 4'hF, 1'b1, 32'h8012_3454);
        chk(cfg_claim && !io_fwd, "R2", {31'd0, cfg_claim}, 32'd1);
        chk(cfg_rdata == 32'd0, "R2", cfg_rdata, 32'd0);
        read_reg(v);
        chk(cfg_claim && v == 32'h8012_3454, "R2", v, 32'h8012_3454);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        req(16'h0CF8, 4'hF, 1'b1, 32'hFFFF_FFFF);
        read_reg(v);
        chk(v == 32'h80FF_FFFC, "R4", v, 32'h80FF_FFFC);
    endtask

    task automatic t_narrow;
        logic [31:0] v;
        req(16'h0CF8, 4'hF, 1'b1, 32'h8001_0800);
        req(16'h0CF8, 4'b0011, 1'b1, 32'h0000_0000);
        chk(io_fwd && !cfg_claim, "R3", {30'd0, io_fwd, cfg_claim}, 32'd2);
        req(16'h0CF8, 4'b0001, 1'b0, '0);
        chk(io_fwd && !cfg_claim, "R3", {30'd0, io_fwd, cfg_claim}, 32'd2);
        read_reg(v);
        chk(v == 32'h8001_0800, "R3", v, 32'h8001_0800);
    endtask

    task automatic t_disabled;
        req(16'h0CF8, 4'hF, 1'b1, mk(1'b0, 8'd3, 5'd0));
        req(16'h0CFC, 4'hF, 1'b0, '0);
        chk(io_fwd && !route_valid, "R5", {30'd0, io_fwd, route_valid}, 32'd2);
        req(16'h0CFE, 4'b1100, 1'b1, '0);
        chk(io_fwd && !route_valid, "R5", {30'd0, io_fwd, route_valid}, 32'd2);
    endtask

    task automatic route(input logic [7:0] bus, input logic [4:0] dev,
                         input logic [2:0] etgt, input bit etype, input string r);
        req(16'h0CF8, 4'hF, 1'b1, mk(1'b1, bus, dev));
        req(16'h0CFD, 4'b0010, 1'b0, '0);
        chk(route_valid && !io_fwd, "R5", {30'd0, route_valid, io_fwd}, 32'd2);
        chk(route_target == etgt && route_type1 == etype, r,
            {28'd0, route_target, route_type1}, {28'd0, etgt, etype});
    endtask

    task automatic t_routes;
        sec_bus = 8'd2; sub_bus = 8'd5;
        route(8'd0, 5'd0, 3'b001, 1'b0, "R6");
        route(8'd0, 5'd2, 3'b001, 1'b0, "R6");
        route(8'd0, 5'd3, 3'b100, 1'b0, "R7");
        route(8'd0, 5'd31, 3'b100, 1'b0, "R7");
        route(8'd2, 5'd0, 3'b010, 1'b0, "R8");
        route(8'd3, 5'd4, 3'b010, 1'b1, "R9");
        route(8'd5, 5'd0, 3'b010, 1'b1, "R9");
        route(8'd6, 5'd0, 3'b100, 1'b1, "R10");
        route(8'd1, 5'd0, 3'b100, 1'b1, "R10");
        sec_bus = 8'd7; sub_bus = 8'd7;
        route(8'd7, 5'd9, 3'b010, 1'b0, "R8");
        route(8'd8, 5'd0, 3'b100, 1'b1, "R10");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_write_read();
                t_reserved();
                t_narrow();
                t_disabled();
                t_routes();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule